// File: doc/BRIEF.md
# Power-Down Clock Sequencer

This block walks a clock generator into and out of its low-power state. An active-low power-down pin arrives asynchronously; the sequencer synchronizes it, parks the internal CPU clock output low on a falling edge, waits until every auxiliary output group has also parked low in its own clock domain, and only then drops the VCO enable and, one cycle later, the crystal oscillator enable. The analog PLL and the oscillator are not part of the block; they are represented only by these two enables.

When the pin is released, the sequencer raises both enables on the same edge. It keeps every output held while it counts a parameterized number of rising edges of a free-running slow clock. With the default 64 edges of a 32.768 kHz clock, this settle wait is about 1.95 ms, inside the 3 ms wake budget. After the wait, each hold is released in the low phase of its own clock, so the first pulse that leaves is a full one.

While the block is in run, a CPU clock-stop request also holds the CPU output. Inside the power-down sequence that request has no effect. The block carries no data stream, so all of its pins are plain level controls with no valid/ready handshake.

Top module: `pdseq_top`

## Requirements
- R1: After reset, cpu_hold is 0, every aux_hold bit is 0, and vco_en and xtal_en are both 1.
- R2: pd_n passes a two-stage synchronizer on clk. When pd_n falls during the high phase of clk, cpu_hold rises on the fourth falling clk edge after that fall.
- R3: vco_en falls only while cpu_hold and every aux_hold bit are 1. xtal_en falls exactly one clk cycle after vco_en falls.
- R4: Each aux_hold[i] follows the hold request through a two-stage synchronizer clocked by aux_clk[i]. It changes only on a falling edge of aux_clk[i], so parking can take several aux cycles.
- R5: A low on cpu_stop_n (synchronized) holds cpu_hold at 1 while the sequencer is running. From power-down entry until the settle wait has ended, cpu_stop_n has no effect on any output.
- R6: While pd_n stays low after entry, vco_en and xtal_en stay 0 and all holds stay 1. vco_en is never 1 while xtal_en is 0.
- R7: When pd_n returns high, xtal_en and vco_en rise on the same clk edge while all holds remain 1.
- R8: The holds are released only after the settle wait. Between the rise of vco_en and the fall of cpu_hold, slow_clk shows SETTLE_TICKS rising edges, within one edge either way for synchronizer alignment.
- R9: cpu_hold changes only on a falling edge of clk. After the release, every aux_hold bit returns to 0.
- R10: If pd_n falls again during the settle wait, vco_en and then xtal_en drop again in the same order as on entry, and no hold is released.
- R11: If cpu_stop_n is low throughout a power-down cycle, cpu_hold stays 1 after the settle wait and falls only once cpu_stop_n goes high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal CPU clock; the sequencer runs on its rising edge, the CPU hold on its falling edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| slow_clk | input | 1 | Free-running slow clock used to time the settle wait |
| aux_clk | input | N_AUX | Clocks of the auxiliary output groups (reference, 48 MHz) |
| pd_n | input | 1 | Asynchronous active-low power-down request |
| cpu_stop_n | input | 1 | Asynchronous active-low CPU clock-stop request |
| cpu_hold | output | 1 | Holds the CPU clock outputs low when 1 |
| aux_hold | output | N_AUX | Per-group hold, 1 parks that group low |
| vco_en | output | 1 | Enable for the VCO |
| xtal_en | output | 1 | Enable for the crystal oscillator |

## Verification
If the state register is wrong, the event order at the ports breaks at once. Examples are an enable dropping while a hold is still low, the crystal stopping before the VCO, or the enables rising in different cycles; these show within one clk cycle of the faulty transition. A wrong settle counter shows as a release one or more slow-clock edges too early or too late, visible when cpu_hold falls. A missed synchronizer stage or a hold register on the wrong edge shows in the entry latency or in a hold changing while its clock is high, on the very edge it happens.

// File: rtl/pdseq_pkg.sv
package pdseq_pkg;
  typedef enum logic [2:0] {
    ST_RUN       = 3'd0,
    ST_HOLD_LOW  = 3'd1,
    ST_VCO_OFF   = 3'd2,
    ST_XTAL_OFF  = 3'd3,
    ST_WAKE_WAIT = 3'd4,
    ST_RELEASE   = 3'd5
  } pd_state_e;
endpackage

// File: rtl/pdseq_sync.sv
module pdseq_sync #(
  parameter int STAGES  = 2,
  parameter bit RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= {STAGES{RST_VAL}};
    else        chain_q <= {chain_q[STAGES-2:0], d};
  end

  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/pdseq_park.sv
// Parks one auxiliary clock group: the hold request crosses into the
// group's own clock and is applied on that clock's falling edge.
module pdseq_park #(
  parameter int SYNC_STAGES = 2
) (
  input  logic aux_clk,
  input  logic rst_n,
  input  logic hold_req,
  output logic aux_hold
);
  logic req_s;

  pdseq_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_req_sync (
    .clk   (aux_clk),
    .rst_n (rst_n),
    .d     (hold_req),
    .q     (req_s)
  );

  always_ff @(negedge aux_clk or negedge rst_n) begin
    if (!rst_n) aux_hold <= 1'b0;
    else        aux_hold <= req_s;
  end
endmodule

// File: rtl/pdseq_wake_timer.sv
// Counts rising edges of the slow clock while run is high.
module pdseq_wake_timer #(
  parameter int SETTLE_TICKS = 64,
  parameter int SYNC_STAGES  = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic slow_clk,
  input  logic run,
  output logic done
);
  localparam int CW = $clog2(SETTLE_TICKS + 1);
  localparam logic [CW-1:0] LIMIT = CW'(SETTLE_TICKS);

  logic          slow_s;
  logic          slow_d;
  logic          tick;
  logic [CW-1:0] cnt_q;

  pdseq_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_slow_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (slow_clk),
    .q     (slow_s)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) slow_d <= 1'b0;
    else        slow_d <= slow_s;
  end

  assign tick = slow_s & ~slow_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        cnt_q <= '0;
    else if (!run)                     cnt_q <= '0;
    else if (tick && (cnt_q != LIMIT)) cnt_q <= cnt_q + 1'b1;
  end

  assign done = run && (cnt_q == LIMIT);
endmodule

// File: rtl/pdseq_fsm.sv
module pdseq_fsm
  import pdseq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic pd_req,
  input  logic stop_req,
  input  logic cpu_parked,
  input  logic aux_all_set,
  input  logic aux_all_clear,
  input  logic wake_done,
  output logic hold_req_q,
  output logic stop_hold_q,
  output logic vco_en_q,
  output logic xtal_en_q,
  output logic wake_run
);
  pd_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_RUN:       if (pd_req) state_d = ST_HOLD_LOW;
      ST_HOLD_LOW:  if (cpu_parked && aux_all_set) state_d = ST_VCO_OFF;
      ST_VCO_OFF:   state_d = ST_XTAL_OFF;
      ST_XTAL_OFF:  if (!pd_req) state_d = ST_WAKE_WAIT;
      ST_WAKE_WAIT: begin
        if (pd_req)         state_d = ST_VCO_OFF;
        else if (wake_done) state_d = ST_RELEASE;
      end
      ST_RELEASE: begin
        if (pd_req)                             state_d = ST_HOLD_LOW;
        else if (!cpu_parked && aux_all_clear)  state_d = ST_RUN;
      end
      default: state_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_RUN;
      hold_req_q  <= 1'b0;
      stop_hold_q <= 1'b0;
      vco_en_q    <= 1'b1;
      xtal_en_q   <= 1'b1;
    end else begin
      state_q     <= state_d;
      hold_req_q  <= state_d inside {ST_HOLD_LOW, ST_VCO_OFF, ST_XTAL_OFF, ST_WAKE_WAIT};
      stop_hold_q <= stop_req && (state_d inside {ST_RUN, ST_RELEASE});
      vco_en_q    <= !(state_d inside {ST_VCO_OFF, ST_XTAL_OFF});
      xtal_en_q   <= (state_d != ST_XTAL_OFF);
    end
  end

  assign wake_run = (state_q == ST_WAKE_WAIT);
endmodule

// File: rtl/pdseq_top.sv
module pdseq_top #(
  parameter int N_AUX        = 2,
  parameter int SYNC_STAGES  = 2,
  parameter int SETTLE_TICKS = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             slow_clk,
  input  logic [N_AUX-1:0] aux_clk,
  input  logic             pd_n,
  input  logic             cpu_stop_n,
  output logic             cpu_hold,
  output logic [N_AUX-1:0] aux_hold,
  output logic             vco_en,
  output logic             xtal_en
);
  logic             pd_s, stop_s;
  logic             hold_req_q, stop_hold_q, wake_run, wake_done;
  logic             cpu_pd_hold_q, cpu_stop_hold_q;
  logic [N_AUX-1:0] aux_ack;

  pdseq_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_pd_sync (
    .clk(clk), .rst_n(rst_n), .d(pd_n), .q(pd_s)
  );

  pdseq_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_stop_sync (
    .clk(clk), .rst_n(rst_n), .d(cpu_stop_n), .q(stop_s)
  );

  // CPU group: holds are applied and removed in the low phase of clk.
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cpu_pd_hold_q   <= 1'b0;
      cpu_stop_hold_q <= 1'b0;
    end else begin
      cpu_pd_hold_q   <= hold_req_q;
      cpu_stop_hold_q <= stop_hold_q;
    end
  end

  assign cpu_hold = cpu_pd_hold_q | cpu_stop_hold_q;

  for (genvar g = 0; g < N_AUX; g++) begin : g_aux
    pdseq_park #(.SYNC_STAGES(SYNC_STAGES)) u_park (
      .aux_clk  (aux_clk[g]),
      .rst_n    (rst_n),
      .hold_req (hold_req_q),
      .aux_hold (aux_hold[g])
    );
    pdseq_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_ack_sync (
      .clk(clk), .rst_n(rst_n), .d(aux_hold[g]), .q(aux_ack[g])
    );
  end

  pdseq_wake_timer #(.SETTLE_TICKS(SETTLE_TICKS), .SYNC_STAGES(SYNC_STAGES)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .slow_clk (slow_clk),
    .run      (wake_run),
    .done     (wake_done)
  );

  pdseq_fsm u_fsm (
    .clk           (clk),
    .rst_n         (rst_n),
    .pd_req        (~pd_s),
    .stop_req      (~stop_s),
    .cpu_parked    (cpu_pd_hold_q),
    .aux_all_set   (&aux_ack),
    .aux_all_clear (~|aux_ack),
    .wake_done     (wake_done),
    .hold_req_q    (hold_req_q),
    .stop_hold_q   (stop_hold_q),
    .vco_en_q      (vco_en),
    .xtal_en_q     (xtal_en),
    .wake_run      (wake_run)
  );
endmodule

// File: rtl/pdseq_chk.sv
module pdseq_chk #(
  parameter int N_AUX = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cpu_hold,
  input logic [N_AUX-1:0] aux_hold,
  input logic             vco_en,
  input logic             xtal_en
);
  AST_VCO_OFF_AFTER_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(vco_en) |-> (cpu_hold && (&aux_hold))); // R3

  AST_XTAL_OFF_AFTER_VCO: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(xtal_en) |-> $past(!vco_en)); // R3

  AST_HELD_WHILE_XTAL_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !xtal_en |-> (cpu_hold && (&aux_hold))); // R6

  AST_VCO_NEEDS_XTAL: assert property (@(posedge clk) disable iff (!rst_n)
    vco_en |-> xtal_en); // R6

  AST_ENABLES_RISE_TOGETHER: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(xtal_en) |-> (vco_en && cpu_hold)); // R7

  AST_RELEASE_WITH_ENABLES: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cpu_hold) |-> (vco_en && xtal_en)); // R8
endmodule

bind pdseq_top pdseq_chk #(.N_AUX(N_AUX)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cpu_hold (cpu_hold),
  .aux_hold (aux_hold),
  .vco_en   (vco_en),
  .xtal_en  (xtal_en)
);

// File: tb/pdseq_top_tb_top.sv
`timescale 1ns/1ps
module pdseq_top_tb_top;
  localparam int N_AUX  = 2;
  localparam int SETTLE = 64;

  logic             clk = 1'b0, rst_n = 1'b0, slow_clk = 1'b0;
  logic             pd_n = 1'b1, cpu_stop_n = 1'b1;
  logic [N_AUX-1:0] aux_clk = '0;
  logic             cpu_hold, vco_en, xtal_en;
  logic [N_AUX-1:0] aux_hold;

  always #4  clk        = ~clk;
  always #40 slow_clk   = ~slow_clk;
  always #35 aux_clk[0] = ~aux_clk[0];
  always #10 aux_clk[1] = ~aux_clk[1];

  pdseq_top #(.N_AUX(N_AUX), .SETTLE_TICKS(SETTLE)) dut_i (
    .clk(clk), .rst_n(rst_n), .slow_clk(slow_clk), .aux_clk(aux_clk),
    .pd_n(pd_n), .cpu_stop_n(cpu_stop_n), .cpu_hold(cpu_hold),
    .aux_hold(aux_hold), .vco_en(vco_en), .xtal_en(xtal_en)
  );

  int checks = 0, errors = 0;

  task automatic check_eq(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  typedef enum int {EV_CPU_ON, EV_CPU_OFF, EV_VCO_OFF, EV_VCO_ON, EV_XTAL_OFF, EV_XTAL_ON} ev_e;
  typedef struct { ev_e ev; string req; } exp_t;
  exp_t exp_q[$];

  task automatic expect_ev(ev_e e, string req);
    exp_t x;
    x.ev = e; x.req = req;
    exp_q.push_back(x);
  endtask

  task automatic observe(ev_e e);
    exp_t x;
    if (exp_q.size() == 0) begin
      checks++; errors++;
      $display("FAIL R5 unexpected output event actual=%0d expected=none", int'(e));
    end else begin
      x = exp_q.pop_front();
      check_eq(x.req, "output event order", int'(e), int'(x.ev));
    end
  endtask

  // Monitor: one sample per cycle, away from both clock edges.
  bit   mon_on = 1'b0;
  logic p_cpu, p_vco, p_xtal;
  always begin
    @(negedge clk); #2;
    if (mon_on) begin
      if (xtal_en !== p_xtal) observe(xtal_en ? EV_XTAL_ON : EV_XTAL_OFF);
      if (vco_en  !== p_vco)  observe(vco_en  ? EV_VCO_ON  : EV_VCO_OFF);
      if (cpu_hold !== p_cpu) observe(cpu_hold ? EV_CPU_ON : EV_CPU_OFF);
    end
    p_cpu = cpu_hold; p_vco = vco_en; p_xtal = xtal_en;
  end

  always @(cpu_hold)    if (mon_on) check_eq("R9", "cpu_hold changes in clk low phase", int'(clk), 0);
  always @(aux_hold[0]) if (mon_on) check_eq("R4", "aux_hold[0] changes in low phase", int'(aux_clk[0]), 0);
  always @(aux_hold[1]) if (mon_on) check_eq("R4", "aux_hold[1] changes in low phase", int'(aux_clk[1]), 0);

  bit counting = 1'b0;
  int slow_cnt = 0;
  always @(posedge slow_clk) if (counting) slow_cnt++;

  task automatic cyc(int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    #(150000 * 8);
    checks++; errors++;
    $display("FAIL watchdog expired actual=1 expected=0");
    summary();
    $finish;
  end

  initial begin
    int n;
    cyc(5);
    check_eq("R1", "reset cpu_hold", int'(cpu_hold), 0);
    check_eq("R1", "reset aux_hold", int'(aux_hold), 0);
    check_eq("R1", "reset vco_en", int'(vco_en), 1);
    check_eq("R1", "reset xtal_en", int'(xtal_en), 1);
    rst_n = 1'b1;
    cyc(3);
    mon_on = 1'b1;

    // Entry, sleep, exit
    expect_ev(EV_CPU_ON, "R2"); expect_ev(EV_VCO_OFF, "R3"); expect_ev(EV_XTAL_OFF, "R3");
    pd_n = 1'b0;
    n = 0;
    while (!cpu_hold) begin @(negedge clk); n++; #1; end
    check_eq("R2", "falling edges to cpu_hold", n, 4);
    wait (!xtal_en);
    cyc(2);
    check_eq("R4", "aux groups parked", int'(aux_hold), 3);
    check_eq("R6", "vco off in sleep", int'(vco_en), 0);
    cyc(40);
    check_eq("R6", "xtal stays off", int'(xtal_en), 0);
    check_eq("R6", "cpu stays held", int'(cpu_hold), 1);
    cpu_stop_n = 1'b0; cyc(10);
    cpu_stop_n = 1'b1; cyc(10);
    check_eq("R5", "stop ignored in sleep, cpu_hold", int'(cpu_hold), 1);
    check_eq("R5", "stop ignored in sleep, vco_en", int'(vco_en), 0);

    expect_ev(EV_XTAL_ON, "R7"); expect_ev(EV_VCO_ON, "R7"); expect_ev(EV_CPU_OFF, "R8");
    pd_n = 1'b1;
    wait (vco_en);
    slow_cnt = 0; counting = 1'b1;
    #1;
    check_eq("R7", "xtal up with vco", int'(xtal_en), 1);
    check_eq("R7", "holds kept on wake", int'(aux_hold), 3);
    wait (!cpu_hold);
    counting = 1'b0;
    check_eq("R8", "settle edges within window",
             int'(slow_cnt >= SETTLE - 1 && slow_cnt <= SETTLE + 1), 1);
    wait (aux_hold == 2'b00);
    cyc(4);
    check_eq("R9", "aux released", int'(aux_hold), 0);

    // Clock stop in run
    expect_ev(EV_CPU_ON, "R5");
    cpu_stop_n = 1'b0; cyc(6);
    check_eq("R5", "stop holds cpu", int'(cpu_hold), 1);
    check_eq("R5", "stop leaves vco on", int'(vco_en), 1);
    expect_ev(EV_CPU_OFF, "R5");
    cpu_stop_n = 1'b1; cyc(6);
    check_eq("R5", "stop released", int'(cpu_hold), 0);

    // Re-entry during the settle wait
    expect_ev(EV_CPU_ON, "R10"); expect_ev(EV_VCO_OFF, "R10"); expect_ev(EV_XTAL_OFF, "R10");
    pd_n = 1'b0;
    wait (!xtal_en);
    cyc(5);
    expect_ev(EV_XTAL_ON, "R10"); expect_ev(EV_VCO_ON, "R10");
    pd_n = 1'b1;
    wait (vco_en);
    cyc(20);
    check_eq("R10", "still held in settle wait", int'(cpu_hold), 1);
    expect_ev(EV_VCO_OFF, "R10"); expect_ev(EV_XTAL_OFF, "R10");
    pd_n = 1'b0;
    wait (!xtal_en);
    cyc(2);
    check_eq("R10", "cpu hold kept on re-entry", int'(cpu_hold), 1);
    check_eq("R10", "aux holds kept on re-entry", int'(aux_hold), 3);
    expect_ev(EV_XTAL_ON, "R10"); expect_ev(EV_VCO_ON, "R10"); expect_ev(EV_CPU_OFF, "R10");
    pd_n = 1'b1;
    wait (!cpu_hold);
    wait (aux_hold == 2'b00);
    cyc(4);

    // Stop request held across a full power-down cycle
    expect_ev(EV_CPU_ON, "R11");
    cpu_stop_n = 1'b0; cyc(6);
    expect_ev(EV_VCO_OFF, "R11"); expect_ev(EV_XTAL_OFF, "R11");
    pd_n = 1'b0;
    wait (!xtal_en);
    cyc(5);
    expect_ev(EV_XTAL_ON, "R11"); expect_ev(EV_VCO_ON, "R11");
    pd_n = 1'b1;
    wait (vco_en);
    wait (aux_hold == 2'b00);
    cyc(10);
    check_eq("R11", "stop still holds cpu after wake", int'(cpu_hold), 1);
    expect_ev(EV_CPU_OFF, "R11");
    cpu_stop_n = 1'b1; cyc(6);
    check_eq("R11", "cpu released after stop", int'(cpu_hold), 0);

    cyc(10);
    check_eq("R3", "all expected events seen", exp_q.size(), 0);
    summary();
    $finish;
  end
endmodule